// File: doc/BRIEF.md
# Backlight PWM Generator with Staged Settings

This block produces one pulse-width-modulated waveform for a display backlight. Software programs it through four word-wide registers. The registers hold a run bit, a commit bit, a prescaler control word and a waveform control word. A prescaler divides the input clock, and a period counter advanced by the prescaler sets the cycle length. The output is high while the period count is below the programmed high width.

Software writes land in staged copies of the settings. In staged mode, the counters keep running on the active copy until software raises the commit bit. The staged divider, period and high width then move into the active copy together, at the end of the current waveform cycle. A direct mode bit in the prescaler control word skips staging, so that written values reach the counters on the next clock. Every register can be read back through a registered read port.

Top module: `bl_pwm`

## Requirements
- R1: After reset every register reads zero and the output is low.
- R2: A read returns the last written value of the defined fields of the addressed register, with undefined bits as zero, one clock after the address is presented. The commit bit reads back as written.
- R3: Register map by word address: 0 holds the run bit in bit 0, 1 holds the commit bit in bit 0, 2 holds the direct-mode bit in bit 0 and the 10-bit divider in bits [25:16], and 3 holds the 12-bit period in bits [11:0] and the 13-bit high width in bits [28:16].
- R4: While running, one waveform cycle lasts (divider+1)*(period+1) clocks. The output is high for the first (divider+1)*high-width clocks of it. The first waveform clock is the second clock after the run bit is written to 1.
- R5: A high width of 0 keeps the output low. A high width of period+1 or more keeps it high for the whole cycle.
- R6: Clearing the run bit drives the output low from the second clock after the write and holds both counters at zero. Setting it again restarts the waveform from the start of a cycle.
- R7: In staged mode, writes to the control words leave the waveform unchanged until a commit.
- R8: Writing the commit bit from 0 to 1 marks a pending commit. The staged settings load as a group after the last clock of the waveform cycle in progress once the mark is set, or on the next clock when not running. A strobe written in the last clock of a cycle waits for the following boundary, so no cycle is cut short.
- R9: In direct mode the active settings follow the written values one clock after each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Registered read data |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
The commit strobe and the end of a waveform cycle can fall in the same clock, and so can the moment the strobe becomes pending and the boundary that would load it. The bench holds an old and a new setting apart in the staged and active copies. It then sweeps the clock at which the commit bit is written across every position of an eight-clock cycle. For each offset it records the waveform and compares it clock by clock with a trace computed from R8: the old pattern through the first boundary at or after the second clock following the strobe, and the new pattern from phase zero after it.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  // word addresses of the register map
  localparam int unsigned REG_RUN    = 0;
  localparam int unsigned REG_COMMIT = 1;
  localparam int unsigned REG_PRESC  = 2;
  localparam int unsigned REG_WAVE   = 3;

  // field positions inside the control words
  localparam int unsigned DIV_LSB    = 16;
  localparam int unsigned PER_LSB    = 0;
  localparam int unsigned HI_LSB     = 16;
  localparam int unsigned DIRECT_BIT = 0;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HI_W   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              run_q,
  output logic              direct_q,
  output logic              commit_q,
  output logic              commit_stb,
  output logic [DIV_W-1:0]  sh_div,
  output logic [PER_W-1:0]  sh_per,
  output logic [HI_W-1:0]   sh_hi
);
  localparam logic [DATA_W-1:0] ONE_MASK   = DATA_W'(1);
  localparam logic [DATA_W-1:0] PRESC_MASK =
    ((((DATA_W)'(1) << DIV_W) - 1'b1) << DIV_LSB) | (ONE_MASK << DIRECT_BIT);
  localparam logic [DATA_W-1:0] WAVE_MASK  =
    ((((DATA_W)'(1) << PER_W) - 1'b1) << PER_LSB) |
    ((((DATA_W)'(1) << HI_W) - 1'b1) << HI_LSB);

  logic [DATA_W-1:0] run_w, commit_w, presc_w, wave_w;

  logic hit_run, hit_commit, hit_presc, hit_wave;
  assign hit_run    = wr_en && (wr_addr == ADDR_W'(REG_RUN));
  assign hit_commit = wr_en && (wr_addr == ADDR_W'(REG_COMMIT));
  assign hit_presc  = wr_en && (wr_addr == ADDR_W'(REG_PRESC));
  assign hit_wave   = wr_en && (wr_addr == ADDR_W'(REG_WAVE));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_w    <= '0;
      commit_w <= '0;
      presc_w  <= '0;
      wave_w   <= '0;
    end else begin
      if (hit_run)    run_w    <= wr_data & ONE_MASK;
      if (hit_commit) commit_w <= wr_data & ONE_MASK;
      if (hit_presc)  presc_w  <= wr_data & PRESC_MASK;
      if (hit_wave)   wave_w   <= wr_data & WAVE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_W'(REG_RUN):    rd_data <= run_w;
        ADDR_W'(REG_COMMIT): rd_data <= commit_w;
        ADDR_W'(REG_PRESC):  rd_data <= presc_w;
        ADDR_W'(REG_WAVE):   rd_data <= wave_w;
        default:             rd_data <= '0;
      endcase
    end
  end

  assign run_q      = run_w[0];
  assign commit_q   = commit_w[0];
  assign direct_q   = presc_w[DIRECT_BIT];
  assign commit_stb = hit_commit && wr_data[0] && !commit_w[0];
  assign sh_div     = presc_w[DIV_LSB +: DIV_W];
  assign sh_per     = wave_w[PER_LSB +: PER_W];
  assign sh_hi      = wave_w[HI_LSB +: HI_W];
endmodule

// File: rtl/bl_pwm_stage.sv
module bl_pwm_stage #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             direct,
  input  logic             commit_stb,
  input  logic             boundary,
  input  logic [DIV_W-1:0] sh_div,
  input  logic [PER_W-1:0] sh_per,
  input  logic [HI_W-1:0]  sh_hi,
  output logic [DIV_W-1:0] act_div,
  output logic [PER_W-1:0] act_per,
  output logic [HI_W-1:0]  act_hi,
  output logic             pending
);
  logic take;
  assign take = pending && (boundary || !run);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_div <= '0;
      act_per <= '0;
      act_hi  <= '0;
      pending <= 1'b0;
    end else if (direct) begin
      act_div <= sh_div;
      act_per <= sh_per;
      act_hi  <= sh_hi;
      pending <= 1'b0;
    end else begin
      if (take) begin
        act_div <= sh_div;
        act_per <= sh_per;
        act_hi  <= sh_hi;
        pending <= commit_stb;
      end else if (commit_stb) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] act_div,
  input  logic [PER_W-1:0] act_per,
  input  logic [HI_W-1:0]  act_hi,
  output logic             boundary,
  output logic [DIV_W-1:0] pre_cnt,
  output logic [PER_W-1:0] per_cnt,
  output logic             pwm_out
);
  localparam int CMP_W = ((HI_W > PER_W) ? HI_W : PER_W) + 1;

  logic tick;
  logic [CMP_W-1:0] per_x, hi_x;

  assign tick     = run && (pre_cnt >= act_div);
  assign boundary = tick && (per_cnt >= act_per);
  assign per_x    = CMP_W'(per_cnt);
  assign hi_x     = CMP_W'(act_hi);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= boundary ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= run && (per_x < hi_x);
  end
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HI_W   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  logic             run_q, direct_q, commit_q, commit_stb, boundary, pending;
  logic [DIV_W-1:0] sh_div, act_div, pre_cnt;
  logic [PER_W-1:0] sh_per, act_per, per_cnt;
  logic [HI_W-1:0]  sh_hi, act_hi;

  bl_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .run_q(run_q), .direct_q(direct_q),
    .commit_q(commit_q), .commit_stb(commit_stb),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi)
  );

  bl_pwm_stage #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_stage (
    .clk(clk), .rst(rst), .run(run_q), .direct(direct_q),
    .commit_stb(commit_stb), .boundary(boundary),
    .sh_div(sh_div), .sh_per(sh_per), .sh_hi(sh_hi),
    .act_div(act_div), .act_per(act_per), .act_hi(act_hi), .pending(pending)
  );

  bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_core (
    .clk(clk), .rst(rst), .run(run_q),
    .act_div(act_div), .act_per(act_per), .act_hi(act_hi),
    .boundary(boundary), .pre_cnt(pre_cnt), .per_cnt(per_cnt), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             run_q,
  input logic             direct_q,
  input logic             commit_stb,
  input logic             boundary,
  input logic             pending,
  input logic [DIV_W-1:0] act_div,
  input logic [PER_W-1:0] act_per,
  input logic [HI_W-1:0]  act_hi,
  input logic [DIV_W-1:0] pre_cnt,
  input logic [PER_W-1:0] per_cnt,
  input logic             pwm_out
);
  // R8
  no_midcycle_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!direct_q && run_q && !boundary) |=>
      ($stable(act_div) && $stable(act_per) && $stable(act_hi)));

  // R8
  strobe_marks_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_stb && !direct_q) |=> pending);

  // R6
  stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !pwm_out);

  // R6
  stopped_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (pre_cnt == '0 && per_cnt == '0));

  // R5
  zero_width_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_hi == '0) |=> !pwm_out);
endmodule

bind bl_pwm bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .run_q(run_q), .direct_q(direct_q),
  .commit_stb(commit_stb), .boundary(boundary), .pending(pending),
  .act_div(act_div), .act_per(act_per), .act_hi(act_hi),
  .pre_cnt(pre_cnt), .per_cnt(per_cnt), .pwm_out(pwm_out)
);

// File: tb/bl_pwm_bench.sv
`timescale 1ns/1ps
module bl_pwm_bench;
  localparam int AW = 2;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          pwm_out;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] got;
  logic trace [0:39];

  always #2.5 clk = ~clk;

  bl_pwm u_bl_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  // count highs over n consecutive clocks
  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, got);
      check("R1 reset read", got, '0);
    end
    check("R1 reset output", {31'b0, pwm_out}, 32'd0);

    // R2/R3: readback of defined fields only
    wr(2, 32'hFFFF_FFFF);
    rd(2, got); check("R2 R3 prescaler word", got, 32'h03FF_0001);
    wr(3, 32'hFFFF_FFFF);
    rd(3, got); check("R2 R3 waveform word", got, 32'h1FFF_0FFF);
    wr(1, 32'hFFFF_FFFF);
    rd(1, got); check("R2 commit bit set", got, 32'h1);
    wr(1, 32'h0);
    rd(1, got); check("R2 commit bit clear", got, 32'h0);
    rd(0, got); check("R2 run word", got, 32'h0);

    // R4/R5/R6: exhaustive sweep in direct mode, exact trace from restart
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 4; p++)
        for (int h = 0; h < 6; h++) begin
          int bad;
          bad = -1;
          wr(0, 0);
          wr(2, (d << 16) | 1);
          wr(3, (h << 16) | p);
          wr(0, 1);
          for (int i = 0; i < 2 * (d + 1) * (p + 1) + 2; i++) begin
            logic e;
            @(negedge clk);
            e = (((i / (d + 1)) % (p + 1)) < h);
            if (pwm_out !== e && bad < 0) bad = i;
          end
          check($sformatf("R4 R5 R6 waveform d=%0d p=%0d h=%0d first_bad", d, p, h),
                DW'(bad), DW'(-1));
        end

    // R6: stop forces low and re-run restarts
    wr(2, 32'h0000_0001);
    wr(3, (5 << 16) | 3);
    wr(0, 1);
    repeat (3) @(negedge clk);
    wr(0, 0);
    check("R6 output one clock after stop write (still high)", {31'b0, pwm_out}, 32'd1);
    count_high(4, c);
    check("R6 low after stop", DW'(c), 32'd0);

    // R7: staged writes do not change waveform
    wr(2, 32'h0001_0000);             // divider 1, staged mode
    wr(3, (2 << 16) | 3);             // period 3, width 2
    wr(1, 1); wr(1, 0);               // commit while stopped
    wr(0, 1);
    count_high(16, c);
    check("R8 commit while stopped loads", DW'(c), 32'd8);
    wr(3, (4 << 16) | 1);             // all-high setting, not committed
    wr(2, 32'h0000_0000);
    count_high(16, c);
    check("R7 staged write ignored", DW'(c), 32'd8);
    wr(1, 1); wr(1, 0);
    repeat (10) @(negedge clk);
    count_high(16, c);
    check("R8 committed all-high", DW'(c), 32'd16);

    // R8: commit strobe swept over every clock of an 8-clock cycle
    for (int off = 0; off < 8; off++) begin
      int j, bad;
      wr(0, 0);
      wr(2, 32'h0001_0000);
      wr(3, (2 << 16) | 3);
      wr(1, 1); wr(1, 0);
      wr(3, (1 << 16) | 1);           // new: period 1, width 1
      wr(0, 1);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        trace[i] = pwm_out;
        if (i == off) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'd1; end
        if (i == off + 1) wr_data = 32'd0;
        if (i == off + 2) wr_en = 1'b0;
      end
      j = off + 2;
      while (j % 8 != 7) j++;
      bad = -1;
      for (int i = 0; i < 40; i++) begin
        logic e;
        if (i <= j) e = (((i / 2) % 4) < 2);
        else        e = ((((i - j - 1) / 2) % 2) < 1);
        if (trace[i] !== e && bad < 0) bad = i;
      end
      check($sformatf("R8 commit offset %0d first_bad", off), DW'(bad), DW'(-1));
    end

    // R9: direct mode change while running
    wr(0, 0);
    wr(2, 32'h0000_0001);
    wr(3, (1 << 16) | 3);
    wr(0, 1);
    count_high(8, c);
    check("R9 direct initial", DW'(c), 32'd2);
    wr(3, (4 << 16) | 3);
    @(negedge clk);
    count_high(8, c);
    check("R9 direct update", DW'(c), 32'd8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule